// File: doc/BRIEF.md
# Two-Slot Issue Hazard Checker

This block decides, cycle by cycle, how much of a fetched instruction pair may enter a two-wide in-order pipeline whose schedule is fixed ahead of time. Fetch presents one 64-bit packet. The lower half (`pkt[31:0]`) is the compute slot and may hold only an ALU or branch instruction. The upper half (`pkt[63:32]`) is the memory slot and may hold only a load or store. An all-zero word is a nop and may fill either slot. The block decodes both halves, rejects packets whose slots carry the wrong class, and looks for read-after-write conflicts. A conflict can lie inside one packet, when the memory slot needs the compute slot's result. It can also lie between packets, when a load result is needed one cycle too early.

The outputs are one issue flag per slot, a stall back to fetch, and an illegal-packet flag. While `fetch_stall` is high, fetch holds the same packet. When it is low, fetch moves on by one 8-byte packet. A flush from branch resolution discards the presented packet and clears all pending state.

Top module: `pair_issue_ctl`

## Requirements
- R1: A legal packet with no hazard raises `issue_alu` and `issue_mem` together in the same cycle, with `fetch_stall` and `pkt_illegal` low. `fetch_stall` is never high in a cycle where `issue_mem` is high.
- R2: The compute slot is legal only when it holds a nop, a register ALU op (opcode 0x00, reads rs and rt, writes rd), an immediate ALU op (opcode 0x08, reads rs, writes rt) or a branch (opcode 0x04, reads rs and rt, writes nothing). The memory slot is legal only when it holds a nop, a load (opcode 0x23, reads base rs, writes rt) or a store (opcode 0x2B, reads base rs and data rt). Opcode is bits 31:26, rs is bits 25:21, rt is bits 20:16 and rd is bits 15:11. Any other packet raises `pkt_illegal`, issues nothing and leaves `fetch_stall` low, so fetch moves past the packet.
- R3: The all-zero word is accepted in either slot. It neither writes nor reads a register, and a packet containing it issues both slots.
- R4: If the memory slot reads the compute slot's destination (as base or as store data), the packet splits. In the first cycle only `issue_alu` is high, with `fetch_stall` high. In the next cycle, for the same packet, only `issue_mem` is high and `fetch_stall` is low.
- R5: If either slot reads the destination of a load that issued in the previous cycle, the packet gets one cycle with no issue and `fetch_stall` high. The next cycle evaluates the packet again with no load pending, which may still lead to a split under R4.
- R6: Register 0 is never a source of a hazard, whether it is written by the compute slot or by a load.
- R7: While `flush` is high, nothing issues and all outputs are low. A pending split second half or load latency is cancelled, so the next packet is judged fresh.
- R8: While `pkt_valid` is low, all outputs are low, and a load that issued before the gap no longer delays a consumer after it.
- R9: While `rst_n` is low, all outputs are low whatever the inputs.
- R10: The scheduled four-packet loop runs with no stall, giving 5 useful instructions every 4 cycles. The four packets are nop plus load, pointer decrement plus nop, add plus nop, and branch plus store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_valid | input | 1 | Fetch presents a packet this cycle |
| pkt | input | 64 | Instruction pair: [31:0] compute slot, [63:32] memory slot |
| flush | input | 1 | Branch resolution discards the packet and pending state |
| issue_alu | output | 1 | Compute slot enters the pipeline this cycle |
| issue_mem | output | 1 | Memory slot enters the pipeline this cycle |
| fetch_stall | output | 1 | Fetch must present the same packet again |
| pkt_illegal | output | 1 | Packet violates the slot-class rule and is dropped |

## Verification
The bench targets packets where both hazards and the flush interact. One case is a load-use bubble followed by an in-packet split on the same packet: a design that merged the two would issue the memory slot too early, or stall twice. A flush in the middle of a split must give a fresh first half afterwards; a design that kept split state would issue the memory slot alone. Loads and ALU ops aimed at register 0, and a load followed by an idle cycle, must cause no delay; a design that got these wrong would add a stall the schedule never planned. The loop itself is run for several iterations, and any stall there breaks the 1.25 instructions-per-cycle figure.

// File: rtl/pair_issue_ctl.sv
module pair_issue_ctl (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pkt_valid,
  input  logic [63:0] pkt,
  input  logic        flush,
  output logic        issue_alu,
  output logic        issue_mem,
  output logic        fetch_stall,
  output logic        pkt_illegal
);
  localparam int IW = 32;
  localparam int RW = 5;
  localparam logic [5:0] OP_REG = 6'h00;
  localparam logic [5:0] OP_IMM = 6'h08;
  localparam logic [5:0] OP_BR  = 6'h04;
  localparam logic [5:0] OP_LD  = 6'h23;
  localparam logic [5:0] OP_ST  = 6'h2B;

  logic [IW-1:0] w0, w1;
  assign w0 = pkt[IW-1:0];
  assign w1 = pkt[2*IW-1:IW];

  logic          split_q;
  logic [RW-1:0] ld_q;

  logic nop0, alur0, alui0, br0, ok0;
  logic nop1, ld1, st1, ok1;
  assign nop0  = (w0 == '0);
  assign alur0 = (w0[31:26] == OP_REG) && !nop0;
  assign alui0 = (w0[31:26] == OP_IMM);
  assign br0   = (w0[31:26] == OP_BR);
  assign ok0   = nop0 | alur0 | alui0 | br0;
  assign nop1  = (w1 == '0);
  assign ld1   = (w1[31:26] == OP_LD);
  assign st1   = (w1[31:26] == OP_ST);
  assign ok1   = nop1 | ld1 | st1;

  logic [RW-1:0] dst0, dst1;
  assign dst0 = alur0 ? w0[15:11] : (alui0 ? w0[20:16] : '0);
  assign dst1 = ld1 ? w1[20:16] : '0;

  function automatic logic hit(input logic en, input logic [RW-1:0] src, input logic [RW-1:0] wr);
    return en && (src == wr) && (wr != '0);
  endfunction

  logic lu, raw, live, go;
  assign lu  = hit(alur0 | alui0 | br0, w0[25:21], ld_q) | hit(alur0 | br0, w0[20:16], ld_q)
             | hit(ld1 | st1, w1[25:21], ld_q)          | hit(st1, w1[20:16], ld_q);
  assign raw = hit(ld1 | st1, w1[25:21], dst0) | hit(st1, w1[20:16], dst0);

  assign live        = rst_n && pkt_valid && !flush;
  assign go          = live && ok0 && ok1;
  assign pkt_illegal = live && !(ok0 && ok1);

  always_comb begin
    issue_alu   = 1'b0;
    issue_mem   = 1'b0;
    fetch_stall = 1'b0;
    if (go) begin
      if (split_q) begin
        issue_mem = 1'b1;
      end else if (lu) begin
        fetch_stall = 1'b1;
      end else if (raw) begin
        issue_alu   = 1'b1;
        fetch_stall = 1'b1;
      end else begin
        issue_alu = 1'b1;
        issue_mem = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      split_q <= 1'b0;
      ld_q    <= '0;
    end else begin
      split_q <= go && !split_q && !lu && raw;
      ld_q    <= issue_mem ? dst1 : '0;
    end
  end
endmodule

// File: rtl/pair_issue_ctl_chk.sv
module pair_issue_ctl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        pkt_valid,
  input logic [63:0] pkt,
  input logic        flush,
  input logic        issue_alu,
  input logic        issue_mem,
  input logic        fetch_stall,
  input logic        pkt_illegal
);
  a_r1_stall_excludes_mem: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_stall |-> !issue_mem);

  a_r2_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_illegal |-> !issue_alu && !issue_mem && !fetch_stall);

  a_r4_split_tail: assert property (@(posedge clk) disable iff (!rst_n)
    $past(issue_alu && !issue_mem && fetch_stall) && pkt_valid && !flush
      |-> issue_mem && !issue_alu && !fetch_stall && !pkt_illegal);

  a_r5_one_bubble: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fetch_stall && !issue_alu) && pkt_valid && !flush
      |-> !(fetch_stall && !issue_alu));

  a_r7_flush_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !issue_alu && !issue_mem && !fetch_stall && !pkt_illegal);

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_valid |-> !issue_alu && !issue_mem && !fetch_stall && !pkt_illegal);
endmodule

bind pair_issue_ctl pair_issue_ctl_chk u_chk (.*);

// File: tb/test_pair_issue_ctl.sv
module test_pair_issue_ctl;
  logic clk = 1'b0, rst_n = 1'b0, pkt_valid = 1'b0, flush = 1'b0;
  logic [63:0] pkt = '0;
  logic issue_alu, issue_mem, fetch_stall, pkt_illegal;
  int checks = 0, fails = 0;
  bit done = 1'b0;
  bit m_split = 1'b0;
  logic [4:0] m_ld = '0;

  always #2 clk = ~clk;

  pair_issue_ctl i_pair_issue_ctl (.*);

  localparam logic [31:0] NOP = 32'h0;
  function automatic logic [31:0] e_alu(input logic [4:0] d, s, t); return {6'h00, s, t, d, 11'h021}; endfunction
  function automatic logic [31:0] e_imm(input logic [4:0] d, s);    return {6'h08, s, d, 16'hfffc}; endfunction
  function automatic logic [31:0] e_br(input logic [4:0] s, t);     return {6'h04, s, t, 16'hfffc}; endfunction
  function automatic logic [31:0] e_ld(input logic [4:0] d, b);     return {6'h23, b, d, 16'h0000}; endfunction
  function automatic logic [31:0] e_st(input logic [4:0] t, b);     return {6'h2B, b, t, 16'h0004}; endfunction

  function automatic int kind(input logic [31:0] w);
    if (w == 0) return 0;
    case (w[31:26])
      6'h00: return 1;
      6'h08: return 2;
      6'h04: return 3;
      6'h23: return 4;
      6'h2B: return 5;
      default: return 6;
    endcase
  endfunction

  function automatic logic [4:0] dst(input logic [31:0] w);
    case (kind(w))
      1: return w[15:11];
      2, 4: return w[20:16];
      default: return 5'd0;
    endcase
  endfunction

  function automatic bit reads(input logic [31:0] w, input logic [4:0] r);
    if (r == 0) return 1'b0;
    case (kind(w))
      1, 3, 5: return (w[25:21] == r) || (w[20:16] == r);
      2, 4: return w[25:21] == r;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [3:0] predict(input logic v, f, input logic [63:0] p, output string tag);
    int k0, k1;
    logic [31:0] w0, w1;
    w0 = p[31:0]; w1 = p[63:32];
    k0 = kind(w0); k1 = kind(w1);
    if (!v) begin tag = "R8"; return 4'b0000; end
    if (f) begin tag = "R7"; return 4'b0000; end
    if (!(k0 <= 3 && (k1 == 0 || k1 == 4 || k1 == 5))) begin tag = "R2"; return 4'b0001; end
    if (m_split) begin tag = "R4"; return 4'b0100; end
    if (m_ld != 0 && (reads(w0, m_ld) || reads(w1, m_ld))) begin tag = "R5"; return 4'b0010; end
    if (dst(w0) != 0 && reads(w1, dst(w0))) begin tag = "R4"; return 4'b1010; end
    tag = "R1";
    return 4'b1100;
  endfunction

  task automatic step(input logic v, f, input logic [63:0] p, input string want, output bit st);
    logic [3:0] e, got;
    string tag;
    @(negedge clk);
    pkt_valid = v; flush = f; pkt = p;
    #1;
    e = predict(v, f, p, tag);
    got = {issue_alu, issue_mem, fetch_stall, pkt_illegal};
    checks++;
    if (got !== e) begin
      fails++;
      $display("FAIL %s: outputs {alu,mem,stall,ill} got %b expected %b pkt=%h", (want != "") ? want : tag, got, e, p);
    end
    m_split = (e == 4'b1010);
    m_ld    = e[2] ? dst(p[63:32]) : 5'd0;
    st      = e[1];
  endtask

  task automatic feed(input logic [63:0] p, input string want);
    bit st;
    step(1'b1, 1'b0, p, want, st);
    while (st) step(1'b1, 1'b0, p, want, st);
  endtask

  function automatic logic [4:0] rr();
    return 5'($urandom % 4);
  endfunction

  function automatic logic [31:0] rnd0();
    case ($urandom % 10)
      0: return NOP;
      1, 2: return e_alu(rr(), rr(), rr());
      3, 4: return e_imm(rr(), rr());
      5, 6: return e_br(rr(), rr());
      7: return e_ld(rr(), rr());
      default: return e_alu(rr(), rr(), rr());
    endcase
  endfunction

  function automatic logic [31:0] rnd1();
    case ($urandom % 10)
      0: return NOP;
      1, 2, 3, 4: return e_ld(rr(), rr());
      5, 6, 7: return e_st(rr(), rr());
      8: return 32'hFC00_0000;
      default: return e_ld(rr(), rr());
    endcase
  endfunction

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL R1: watchdog got hung run expected completion");
      finish_run();
    end
  end

  initial begin
    bit st;
    int stalls, cyc;
    logic [63:0] p;
    void'($urandom(32'd4242));

    // R9 reset state with a live packet presented
    @(negedge clk);
    pkt_valid = 1'b1; pkt = {e_ld(5'd2, 5'd1), e_alu(5'd3, 5'd1, 5'd2)};
    #1;
    checks++;
    if ({issue_alu, issue_mem, fetch_stall, pkt_illegal} !== 4'b0000) begin
      fails++;
      $display("FAIL R9: got %b expected 0000", {issue_alu, issue_mem, fetch_stall, pkt_illegal});
    end
    @(negedge clk); pkt_valid = 1'b0; rst_n = 1'b1;

    // R3 nops in both slots and beside real ops
    step(1, 0, {NOP, NOP}, "R3", st);
    step(1, 0, {NOP, e_alu(5'd3, 5'd1, 5'd2)}, "R3", st);
    step(1, 0, {e_st(5'd3, 5'd3), NOP}, "R3", st);
    // R1 independent pair
    step(1, 0, {e_ld(5'd9, 5'd8), e_alu(5'd3, 5'd1, 5'd2)}, "R1", st);
    // R2 slot class violations
    step(1, 0, {NOP, e_ld(5'd4, 5'd1)}, "R2", st);
    step(1, 0, {e_alu(5'd4, 5'd1, 5'd2), NOP}, "R2", st);
    step(1, 0, {32'hFC00_0000, e_br(5'd1, 5'd2)}, "R2", st);
    // R4 split on base and on store data
    feed({e_ld(5'd5, 5'd3), e_alu(5'd3, 5'd1, 5'd2)}, "R4");
    feed({e_st(5'd4, 5'd2), e_imm(5'd4, 5'd1)}, "R4");
    // R6 register zero never creates a hazard
    step(1, 0, {e_ld(5'd6, 5'd0), e_alu(5'd0, 5'd1, 5'd2)}, "R6", st);
    step(1, 0, {e_ld(5'd0, 5'd1), NOP}, "R6", st);
    step(1, 0, {NOP, e_alu(5'd7, 5'd0, 5'd0)}, "R6", st);
    // R5 load-use from each consumer position
    step(1, 0, {e_ld(5'd6, 5'd1), NOP}, "R5", st);
    feed({NOP, e_alu(5'd7, 5'd6, 5'd2)}, "R5");
    step(1, 0, {e_ld(5'd6, 5'd1), NOP}, "R5", st);
    feed({e_st(5'd6, 5'd2), NOP}, "R5");
    step(1, 0, {e_ld(5'd6, 5'd1), NOP}, "R5", st);
    feed({e_ld(5'd9, 5'd6), NOP}, "R5");
    // R5 bubble followed by a split on the same packet
    step(1, 0, {e_ld(5'd6, 5'd1), NOP}, "R5", st);
    feed({e_ld(5'd8, 5'd7), e_alu(5'd7, 5'd6, 5'd1)}, "R5");
    // R7 flush in the middle of a split, then the same packet is fresh
    step(1, 0, {e_ld(5'd5, 5'd3), e_alu(5'd3, 5'd1, 5'd2)}, "R7", st);
    step(1, 1, {e_ld(5'd5, 5'd3), e_alu(5'd3, 5'd1, 5'd2)}, "R7", st);
    feed({e_ld(5'd5, 5'd3), e_alu(5'd3, 5'd1, 5'd2)}, "R7");
    // R7 flush after a load clears the latency
    step(1, 0, {e_ld(5'd6, 5'd1), NOP}, "R7", st);
    step(1, 1, {NOP, NOP}, "R7", st);
    step(1, 0, {NOP, e_alu(5'd7, 5'd6, 5'd2)}, "R7", st);
    // R8 idle gap after a load
    step(1, 0, {e_ld(5'd6, 5'd1), NOP}, "R8", st);
    step(0, 0, {NOP, e_alu(5'd7, 5'd6, 5'd2)}, "R8", st);
    step(1, 0, {NOP, e_alu(5'd7, 5'd6, 5'd2)}, "R8", st);

    // R10 scheduled loop: t0=8, s1=17, s2=18
    stalls = 0; cyc = 0;
    for (int it = 0; it < 6; it++) begin
      step(1, 0, {e_ld(5'd8, 5'd17), NOP}, "R10", st);                 stalls += st; cyc++;
      step(1, 0, {NOP, e_imm(5'd17, 5'd17)}, "R10", st);               stalls += st; cyc++;
      step(1, 0, {NOP, e_alu(5'd8, 5'd8, 5'd18)}, "R10", st);          stalls += st; cyc++;
      step(1, 0, {e_st(5'd8, 5'd17), e_br(5'd17, 5'd0)}, "R10", st);   stalls += st; cyc++;
    end
    checks++;
    if (stalls != 0 || cyc != 24) begin
      fails++;
      $display("FAIL R10: stalls=%0d cycles=%0d expected stalls=0 cycles=24 for 30 instructions", stalls, cyc);
    end

    // constrained random with fetch holding on stall
    st = 1'b0;
    p = {rnd1(), rnd0()};
    for (int n = 0; n < 4000; n++) begin
      logic v, f;
      if (!st) p = {rnd1(), rnd0()};
      v = st ? 1'b1 : (($urandom % 10) != 0);
      f = (($urandom % 25) == 0);
      step(v, f, p, "", st);
      if (f) st = 1'b0;
    end

    done = 1'b1;
    finish_run();
  end
endmodule